// File: doc/BRIEF.md
# Stack-Relative Register Operand Decoder

This block turns the register-operand fields of a variable-length instruction into physical register-file addresses. For each instruction it receives the opcode byte, the two bytes that follow it, the current 7-bit stack pointer and the 7-bit local-frame base. It reports the instruction length in bytes and a format code. For each of the three operands (sources A and B, destination C) it reports a class (local, auxiliary, constant or stack) and a register index. It also reports the signed net stack effect and the stack pointer that results. Execution, branching and memory access belong to other blocks.

A single 4-bit field selects a local, an auxiliary, a constant, or a stack slot that carries an implicit push or pop. Source fields and the destination field read the stack slot codes differently. Every stack-pointer and frame-base sum wraps modulo 128. Stack-slot operands come out as absolute register indices that are already computed.

Instructions enter on a valid/ready handshake and results leave on another. One instruction is taken on each cycle in which `in_valid` and `in_ready` are both high, and its result appears registered on the following cycle. `in_ready` is high when the output register is empty or is being drained in the same cycle. While `out_valid` is high and `out_ready` is low, every result output holds its value and no new instruction is taken.

Top module: `srod_top`

## Requirements
- R1: `out_len` follows opcode bits [7:5]: 000 gives 1, 001 gives 5, 010 and 011 give 1, 100 and 101 give 2, and 110 and 111 give 3.
- R2: Opcodes 0xC0 to 0xCF use the three-register format (`out_fmt`=2). In byte 1, bit 7 is the A opt flag, bit 6 the C opt flag, bit 5 the B opt flag, bit 4 the aux flag, and bits 3:0 the B field. In byte 2, bits 7:4 are the C field and bits 3:0 the A field.
- R3: When an operand's opt flag is clear and aux is set, the class is auxiliary (code 1) and the index is the field value. When both are clear, the class is local (code 0) and the index is (L + field) mod 128.
- R4: When an operand's opt flag is set and its field is 0 to 11, the class is constant (code 2) and the index is the field value, whatever aux holds.
- R5: For a source operand with opt set, the class is stack (code 3). Field 12 gives S and field 13 gives S-1, with no stack effect. Field 14 gives S and field 15 gives S-1, each adding -1 to the stack effect.
- R6: For the destination with opt set, the class is stack. Field 12 gives S and field 13 gives S-1, with no effect. Fields 14 and 15 both give S+1 and add +1 to the stack effect.
- R7: `out_se` is the sum of the three operand effects, as 3-bit two's complement (range -2 to +1). `out_sp` is (S + effect) mod 128.
- R8: Opcodes 0x80 to 0x87 use the quick format (`out_fmt`=1). Operands A and C are stack slot S with no effect. B is decoded as a source from byte 1, with bit 5 as opt, bit 4 as aux and bits 3:0 as the field. Byte 1 bits 7:6 and byte 2 are ignored.
- R9: Any other opcode gives `out_fmt`=0, all operand classes and indices zero, an effect of 0, and `out_sp` equal to S.
- R10: All index arithmetic wraps modulo 128: S-1 at S=0 gives 127, S+1 at S=127 gives 0, and L+field wraps past 127.
- R11: An instruction taken when `in_valid` and `in_ready` are both high gives `out_valid` on the next cycle. While `out_valid` is high and `out_ready` is low, `in_ready` is low and all result outputs hold their values.
- R12: While `rst_n` is low, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction bytes and pointers are valid |
| in_ready | output | 1 | Decoder can take an instruction |
| in_opcode | input | 8 | Opcode byte |
| in_byte1 | input | 8 | First byte after the opcode |
| in_byte2 | input | 8 | Second byte after the opcode |
| in_sp | input | 7 | Stack pointer S at the start of the instruction |
| in_lb | input | 7 | Local-frame base L |
| out_valid | output | 1 | Decoded result is valid |
| out_ready | input | 1 | Consumer takes the result |
| out_len | output | 3 | Instruction length in bytes |
| out_fmt | output | 2 | 0 no register operands, 1 quick, 2 three-register |
| out_a_cls | output | 2 | Class of source A |
| out_a_idx | output | 7 | Index of source A |
| out_b_cls | output | 2 | Class of source B |
| out_b_idx | output | 7 | Index of source B |
| out_c_cls | output | 2 | Class of destination C |
| out_c_idx | output | 7 | Index of destination C |
| out_se | output | 3 | Net stack effect, two's complement |
| out_sp | output | 7 | Stack pointer after the instruction |

## Verification
The only state in this block is the output register, so a fault inside it shows at the ports one cycle after the instruction is taken. Such a fault shows as a swapped or shifted field, a stack slot off by one, a missing wrap, or an effect counted with the wrong sign, in an index or in `out_sp` for that very instruction. The vectors hit each slot code on both the source and the destination side, with S at 0 and at 127 and with L near the top. A broken hold under back-pressure shows as an output that changes while `out_ready` is low, checked on the cycle after the stall begins.

// File: rtl/srod_pkg.sv
package srod_pkg;
  localparam int FLD_W     = 4;
  localparam int NUM_CONST = (1 << FLD_W) - 4;
  localparam int LEN_W     = 3;
  localparam int SE_W      = 3;

  typedef enum logic [1:0] {
    CLS_LOCAL = 2'd0,
    CLS_AUX   = 2'd1,
    CLS_CONST = 2'd2,
    CLS_STACK = 2'd3
  } opd_cls_e;

  typedef enum logic [1:0] {
    FMT_NONE  = 2'd0,
    FMT_QUICK = 2'd1,
    FMT_RR    = 2'd2
  } ifmt_e;

  localparam logic [3:0] RR_OP_HI    = 4'hC;
  localparam logic [4:0] QUICK_OP_HI = 5'b10000;
endpackage

// File: rtl/srod_fmt_dec.sv
module srod_fmt_dec
  import srod_pkg::*;
(
  input  logic [7:0]       opcode,
  output logic [LEN_W-1:0] len,
  output ifmt_e            fmt
);
  logic unused_low;
  assign unused_low = ^opcode[2:0];

  always_comb begin
    unique case (opcode[7:5])
      3'b001:          len = LEN_W'(5);
      3'b100, 3'b101:  len = LEN_W'(2);
      3'b110, 3'b111:  len = LEN_W'(3);
      default:         len = LEN_W'(1);
    endcase
  end

  always_comb begin
    if (opcode[7:4] == RR_OP_HI)         fmt = FMT_RR;
    else if (opcode[7:3] == QUICK_OP_HI) fmt = FMT_QUICK;
    else                                 fmt = FMT_NONE;
  end
endmodule

// File: rtl/srod_opd_field.sv
module srod_opd_field
  import srod_pkg::*;
#(
  parameter int SP_W    = 7,
  parameter bit IS_DEST = 1'b0
) (
  input  logic              opt,
  input  logic              aux,
  input  logic [FLD_W-1:0]  sel,
  input  logic [SP_W-1:0]   sp,
  input  logic [SP_W-1:0]   lb,
  output opd_cls_e          cls,
  output logic [SP_W-1:0]   idx,
  output logic signed [1:0] eff
);
  localparam logic [SP_W-1:0] ONE = SP_W'(1);

  logic [SP_W-1:0]   slot_idx;
  logic signed [1:0] slot_eff;

  // Stack-slot codes differ between destination and source fields
  generate
    if (IS_DEST) begin : g_dest
      always_comb begin
        unique case (sel[1:0])
          2'd0:    begin slot_idx = sp;       slot_eff = 2'sd0; end
          2'd1:    begin slot_idx = sp - ONE; slot_eff = 2'sd0; end
          default: begin slot_idx = sp + ONE; slot_eff = 2'sd1; end
        endcase
      end
    end else begin : g_src
      always_comb begin
        unique case (sel[1:0])
          2'd0:    begin slot_idx = sp;       slot_eff = 2'sd0;  end
          2'd1:    begin slot_idx = sp - ONE; slot_eff = 2'sd0;  end
          2'd2:    begin slot_idx = sp;       slot_eff = -2'sd1; end
          default: begin slot_idx = sp - ONE; slot_eff = -2'sd1; end
        endcase
      end
    end
  endgenerate

  always_comb begin
    eff = 2'sd0;
    if (!opt) begin
      if (aux) begin
        cls = CLS_AUX;
        idx = SP_W'(sel);
      end else begin
        cls = CLS_LOCAL;
        idx = lb + SP_W'(sel);
      end
    end else if (sel < FLD_W'(NUM_CONST)) begin
      cls = CLS_CONST;
      idx = SP_W'(sel);
    end else begin
      cls = CLS_STACK;
      idx = slot_idx;
      eff = slot_eff;
    end
  end
endmodule

// File: rtl/srod_out_stage.sv
module srod_out_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) out_data <= in_data;
    end
  end

  // R11: a stalled result holds still
  a_r11_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  // R11: an accepted instruction appears on the next cycle
  a_r11_accept_next: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);
endmodule

// File: rtl/srod_top.sv
module srod_top
  import srod_pkg::*;
#(
  parameter int SP_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [7:0]       in_opcode,
  input  logic [7:0]       in_byte1,
  input  logic [7:0]       in_byte2,
  input  logic [SP_W-1:0]  in_sp,
  input  logic [SP_W-1:0]  in_lb,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [LEN_W-1:0] out_len,
  output logic [1:0]       out_fmt,
  output logic [1:0]       out_a_cls,
  output logic [SP_W-1:0]  out_a_idx,
  output logic [1:0]       out_b_cls,
  output logic [SP_W-1:0]  out_b_idx,
  output logic [1:0]       out_c_cls,
  output logic [SP_W-1:0]  out_c_idx,
  output logic [SE_W-1:0]  out_se,
  output logic [SP_W-1:0]  out_sp
);
  localparam int OPD_W = 2 + SP_W;
  localparam int RES_W = LEN_W + 2 + 3 * OPD_W + SE_W + SP_W;

  logic [LEN_W-1:0] len;
  ifmt_e            fmt;

  srod_fmt_dec u_fmt (.opcode(in_opcode), .len(len), .fmt(fmt));

  // Byte 1: [7] A opt, [6] C opt, [5] B opt, [4] aux, [3:0] B field
  // Byte 2: [7:4] C field, [3:0] A field
  opd_cls_e          a_cls_f, b_cls_f, c_cls_f;
  logic [SP_W-1:0]   a_idx_f, b_idx_f, c_idx_f;
  logic signed [1:0] a_eff_f, b_eff_f, c_eff_f;

  srod_opd_field #(.SP_W(SP_W), .IS_DEST(1'b0)) u_fld_a (
    .opt(in_byte1[7]), .aux(in_byte1[4]), .sel(in_byte2[3:0]),
    .sp(in_sp), .lb(in_lb), .cls(a_cls_f), .idx(a_idx_f), .eff(a_eff_f));

  srod_opd_field #(.SP_W(SP_W), .IS_DEST(1'b0)) u_fld_b (
    .opt(in_byte1[5]), .aux(in_byte1[4]), .sel(in_byte1[3:0]),
    .sp(in_sp), .lb(in_lb), .cls(b_cls_f), .idx(b_idx_f), .eff(b_eff_f));

  srod_opd_field #(.SP_W(SP_W), .IS_DEST(1'b1)) u_fld_c (
    .opt(in_byte1[6]), .aux(in_byte1[4]), .sel(in_byte2[7:4]),
    .sp(in_sp), .lb(in_lb), .cls(c_cls_f), .idx(c_idx_f), .eff(c_eff_f));

  opd_cls_e          a_cls, b_cls, c_cls;
  logic [SP_W-1:0]   a_idx, b_idx, c_idx;
  logic signed [1:0] a_eff, b_eff, c_eff;

  always_comb begin
    a_cls = CLS_LOCAL; a_idx = '0; a_eff = 2'sd0;
    b_cls = CLS_LOCAL; b_idx = '0; b_eff = 2'sd0;
    c_cls = CLS_LOCAL; c_idx = '0; c_eff = 2'sd0;
    unique case (fmt)
      FMT_RR: begin
        a_cls = a_cls_f; a_idx = a_idx_f; a_eff = a_eff_f;
        b_cls = b_cls_f; b_idx = b_idx_f; b_eff = b_eff_f;
        c_cls = c_cls_f; c_idx = c_idx_f; c_eff = c_eff_f;
      end
      FMT_QUICK: begin
        a_cls = CLS_STACK; a_idx = in_sp;
        b_cls = b_cls_f;   b_idx = b_idx_f; b_eff = b_eff_f;
        c_cls = CLS_STACK; c_idx = in_sp;
      end
      default: ;
    endcase
  end

  logic [SE_W-1:0] se;
  logic [SP_W-1:0] sp_next;

  assign se = {a_eff[1], a_eff} + {b_eff[1], b_eff} + {c_eff[1], c_eff};
  assign sp_next = in_sp + {{(SP_W - SE_W){se[SE_W-1]}}, se};

  logic [RES_W-1:0] res_in, res_out;

  assign res_in = {len, fmt, a_cls, a_idx, b_cls, b_idx, c_cls, c_idx, se, sp_next};

  srod_out_stage #(.W(RES_W)) u_stage (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(res_in),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(res_out));

  assign {out_len, out_fmt, out_a_cls, out_a_idx, out_b_cls, out_b_idx,
          out_c_cls, out_c_idx, out_se, out_sp} = res_out;

  // R7: net effect never leaves -2..+1
  a_r7_effect_range: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_se != 3'd2) && (out_se != 3'd3));

  // R8: quick format keeps A and C on the same slot with no push
  a_r8_quick_slots: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_fmt == FMT_QUICK |->
      out_a_cls == CLS_STACK && out_c_cls == CLS_STACK &&
      out_a_idx == out_c_idx && out_se != 3'd1);

  // R9: opcodes without register operands leave the stack alone
  a_r9_none_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_fmt == FMT_NONE |->
      out_se == '0 && out_a_idx == '0 && out_b_idx == '0 && out_c_idx == '0);

  // R1: operand-carrying formats have their fixed lengths
  a_r1_len_by_fmt: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_fmt != FMT_NONE |->
      out_len == ((out_fmt == FMT_RR) ? LEN_W'(3) : LEN_W'(2)));
endmodule

// File: tb/srod_top_bench.sv
`timescale 1ns/1ps
module srod_top_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, out_ready = 1'b1;
  logic [7:0] in_opcode = '0, in_byte1 = '0, in_byte2 = '0;
  logic [6:0] in_sp = '0, in_lb = '0;
  logic in_ready, out_valid;
  logic [2:0] out_len, out_se;
  logic [1:0] out_fmt, out_a_cls, out_b_cls, out_c_cls;
  logic [6:0] out_a_idx, out_b_idx, out_c_idx, out_sp;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  srod_top u_srod_top (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_opcode(in_opcode), .in_byte1(in_byte1), .in_byte2(in_byte2),
    .in_sp(in_sp), .in_lb(in_lb), .out_valid(out_valid), .out_ready(out_ready),
    .out_len(out_len), .out_fmt(out_fmt),
    .out_a_cls(out_a_cls), .out_a_idx(out_a_idx),
    .out_b_cls(out_b_cls), .out_b_idx(out_b_idx),
    .out_c_cls(out_c_cls), .out_c_idx(out_c_idx),
    .out_se(out_se), .out_sp(out_sp));

  // stimulus: op, b1, b2, S, L | expected: len, fmt, A cls/idx, B cls/idx, C cls/idx, effect, new S
  localparam int NV = 16;
  localparam logic [79:0] VEC [NV] = '{
    {8'hC4,8'h00,8'h35,7'd10,7'd120, 3'd3,2'd2, 2'd0,7'd125, 2'd0,7'd120, 2'd0,7'd123, 3'd0,7'd10},
    {8'hC0,8'hEE,8'hFF,7'd0,7'd0,    3'd3,2'd2, 2'd3,7'd127, 2'd3,7'd0,   2'd3,7'd1,   3'd7,7'd127},
    {8'hCF,8'h17,8'h29,7'd5,7'd3,    3'd3,2'd2, 2'd1,7'd9,   2'd1,7'd7,   2'd1,7'd2,   3'd0,7'd5},
    {8'hC8,8'hFB,8'hC0,7'd127,7'd64, 3'd3,2'd2, 2'd2,7'd0,   2'd2,7'd11,  2'd3,7'd127, 3'd0,7'd127},
    {8'hC1,8'hAD,8'hDC,7'd0,7'd120,  3'd3,2'd2, 2'd3,7'd0,   2'd3,7'd127, 2'd0,7'd5,   3'd0,7'd0},
    {8'hC2,8'h44,8'hE1,7'd127,7'd10, 3'd3,2'd2, 2'd0,7'd11,  2'd0,7'd14,  2'd3,7'd0,   3'd1,7'd0},
    {8'h84,8'hEF,8'hAB,7'd1,7'd9,    3'd2,2'd1, 2'd3,7'd1,   2'd3,7'd0,   2'd3,7'd1,   3'd7,7'd0},
    {8'h87,8'h06,8'h00,7'd20,7'd100, 3'd2,2'd1, 2'd3,7'd20,  2'd0,7'd106, 2'd3,7'd20,  3'd0,7'd20},
    {8'h46,8'hFF,8'hFF,7'd33,7'd44,  3'd1,2'd0, 2'd0,7'd0,   2'd0,7'd0,   2'd0,7'd0,   3'd0,7'd33},
    {8'h25,8'hFF,8'hFF,7'd64,7'd1,   3'd5,2'd0, 2'd0,7'd0,   2'd0,7'd0,   2'd0,7'd0,   3'd0,7'd64},
    {8'h0A,8'hFF,8'hFF,7'd2,7'd2,    3'd1,2'd0, 2'd0,7'd0,   2'd0,7'd0,   2'd0,7'd0,   3'd0,7'd2},
    {8'hA0,8'hFF,8'hFF,7'd7,7'd7,    3'd2,2'd0, 2'd0,7'd0,   2'd0,7'd0,   2'd0,7'd0,   3'd0,7'd7},
    {8'hD8,8'hFF,8'hFF,7'd9,7'd9,    3'd3,2'd0, 2'd0,7'd0,   2'd0,7'd0,   2'd0,7'd0,   3'd0,7'd9},
    {8'hF0,8'hFF,8'hFF,7'd100,7'd0,  3'd3,2'd0, 2'd0,7'd0,   2'd0,7'd0,   2'd0,7'd0,   3'd0,7'd100},
    {8'h88,8'hFF,8'hFF,7'd50,7'd0,   3'd2,2'd0, 2'd0,7'd0,   2'd0,7'd0,   2'd0,7'd0,   3'd0,7'd50},
    {8'hC3,8'hAF,8'h0E,7'd0,7'd127,  3'd3,2'd2, 2'd3,7'd0,   2'd3,7'd127, 2'd0,7'd127, 3'd6,7'd126}
  };

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic drive(input logic [79:0] v);
    in_opcode = v[79:72]; in_byte1 = v[71:64]; in_byte2 = v[63:56];
    in_sp = v[55:49]; in_lb = v[48:42];
    in_valid = 1'b1;
  endtask

  function automatic logic [26:0] opd_now();
    return {out_a_cls, out_a_idx, out_b_cls, out_b_idx, out_c_cls, out_c_idx};
  endfunction

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    // R12: reset state
    repeat (3) @(negedge clk);
    chk("R12 out_valid in reset", 64'(out_valid), 64'd0);
    chk("R12 in_ready in reset", 64'(in_ready), 64'd1);
    rst_n = 1'b1;
    @(negedge clk);

    // table walk with the consumer always ready
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i]);
      @(posedge clk);
      @(negedge clk);
      in_valid = 1'b0;
      chk($sformatf("R11 vec %0d out_valid", i), 64'(out_valid), 64'd1);
      chk($sformatf("R1 vec %0d len", i), 64'(out_len), 64'(VEC[i][41:39]));
      chk($sformatf("R2 R8 R9 vec %0d fmt", i), 64'(out_fmt), 64'(VEC[i][38:37]));
      chk($sformatf("R3 R4 R5 R6 R10 vec %0d operands", i), 64'(opd_now()), 64'(VEC[i][36:10]));
      chk($sformatf("R7 vec %0d effect and new S", i), 64'({out_se, out_sp}), 64'(VEC[i][9:0]));
    end
    @(negedge clk);
    chk("R11 idle after drain", 64'(out_valid), 64'd0);

    // R11: back-pressure holds the result and blocks input
    out_ready = 1'b0;
    drive(VEC[0]);
    @(posedge clk);
    @(negedge clk);
    chk("R11 valid under stall", 64'(out_valid), 64'd1);
    drive(VEC[1]);
    @(posedge clk);
    @(negedge clk);
    chk("R11 in_ready low under stall", 64'(in_ready), 64'd0);
    chk("R11 result held under stall", 64'(opd_now()), 64'(VEC[0][36:10]));
    chk("R11 new S held under stall", 64'(out_sp), 64'(VEC[0][6:0]));
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R11 next instruction after release", 64'(opd_now()), 64'(VEC[1][36:10]));
    chk("R7 new S after release", 64'(out_sp), 64'(VEC[1][6:0]));
    @(posedge clk);
    @(negedge clk);
    chk("R11 empty after consume", 64'(out_valid), 64'd0);

    // R12: reset clears a pending result
    out_ready = 1'b0;
    drive(VEC[2]);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    rst_n = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk("R12 reset drops pending result", 64'(out_valid), 64'd0);
    chk("R12 in_ready after reset", 64'(in_ready), 64'd1);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule